// File: doc/BRIEF.md
# Smart-Card Serial Status Flag Controller

This block keeps the receive-error, receive-full and transmit-end status flags of a smart-card style serial port. The shifters, the bit-rate generator and the sampling of the receiver's error signal sit in neighbouring logic. Those neighbours report to this block through strobes: a received character is complete (with a parity verdict), a transmission has started, and a half elementary-time-unit tick has occurred. The block also sees the level of the error-signal flag and the level of the transmit-data-empty flag. From these inputs it keeps the flags and drives two inhibit lines that stall the receiver and, in clocked synchronous mode, the transmitter.

Software reads the flags through a status word. It clears a flag by first reading it while it is 1 and then writing 0 to its bit position. A DMA engine that refills the transmit data register clears the transmit-end flag directly. The transmit-end flag rises after a fixed number of half-etu ticks following the start of a transmission. That count depends on two mode bits: a guard-time mode and a block-transfer mode.

Top module: `sc_status_flags`

## Requirements
- R1: When a character completes with a parity error while reception is enabled and the parity-error flag is 0, the parity-error flag becomes 1 and `rxLoad` pulses for one cycle, but the receive-full flag does not change.
- R2: When a character completes without a parity error while reception is enabled and the parity-error flag is 0, the receive-full flag becomes 1 and `rxLoad` pulses for one cycle.
- R3: While the parity-error flag is 1, completed characters are ignored: there is no `rxLoad` and no flag change. `rxBlock` is 1, and `txBlock` equals `syncMode`.
- R4: The parity-error flag (status bit 3) clears only when 0 is written to bit 3 after a status read that returned it as 1. A write of 0 without such a read leaves the flag at 1.
- R5: Changing `rxEnable` never changes the parity-error flag.
- R6: The transmit-end flag is 1 after reset. It is forced to 1 in every cycle where `txEnable` is 0 and `errSignal` is 0.
- R7: After `txStart`, the transmit-end flag is set on the Nth `halfTick`, where N is 25 (guard 0, block 0), 23 (guard 0, block 1) or 22 (guard 1). The flag is visible in the next cycle and is set only if `errSignal` is 0 and `txEmpty` is 1 at that tick. A new `txStart` restarts the count.
- R8: If `errSignal` is 1 on the expiring tick, the transmit-end flag stays 0 and the count is abandoned until the next `txStart`.
- R9: The transmit-end flag clears when 0 is written to status bit 7 (transmit-empty) after a status read that returned bit 7 as 1. A write without such a read has no effect.
- R10: A `dmaTxWrite` strobe clears the transmit-end flag.
- R11: When a set event and a clear event hit the same flag in the same cycle, the flag becomes 1.
- R12: The receive-full flag (status bit 6) clears when 0 is written to bit 6 after a status read that returned it as 1. Status bit 2 reads the transmit-end flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| halfTick | input | 1 | One pulse per half elementary time unit |
| txStart | input | 1 | Transmission of a character begins |
| rxDone | input | 1 | A received character is complete |
| rxParityErr | input | 1 | Parity verdict qualifying `rxDone` |
| errSignal | input | 1 | Error-signal status flag level |
| txEmpty | input | 1 | Transmit data register empty flag level |
| guardMode | input | 1 | Guard-time mode bit |
| blockMode | input | 1 | Block-transfer mode bit |
| syncMode | input | 1 | Clocked synchronous mode |
| txEnable | input | 1 | Transmitter enable |
| rxEnable | input | 1 | Receiver enable |
| regRd | input | 1 | Status word read strobe |
| regWr | input | 1 | Status word write strobe |
| wrData | input | 8 | Status word write data |
| dmaTxWrite | input | 1 | DMA wrote the transmit data register |
| rdData | output | 8 | Status word: bit 7 empty, bit 6 full, bit 3 parity error, bit 2 transmit end |
| parErr | output | 1 | Parity-error flag |
| rxFull | output | 1 | Receive-full flag |
| txEnd | output | 1 | Transmit-end flag |
| rxLoad | output | 1 | Pulse: move received data into the receive data register |
| rxBlock | output | 1 | Receiver inhibit |
| txBlock | output | 1 | Transmitter inhibit |

## Verification
Some rules relate only neighbouring cycles, and the assertions check those on every cycle. These are: setting the parity-error flag on a bad character, the stall on characters that arrive while it is set, the flag holding without a write, its indifference to the receive enable, the forced transmit-end state and the DMA clear. Other behaviours need history, and only the bench's scenarios show them. These are the tick counts of the three delay modes, the restart on a new start strobe, the abandoned count after an error signal, the read-then-write clearing sequence and set-over-clear priority. A seeded random phase drives the receive flags and the clear handshake against a reference model in the bench.

// File: rtl/sc_status_pkg.sv
package sc_status_pkg;
  localparam int STAT_W    = 8;
  localparam int BIT_EMPTY = 7;
  localparam int BIT_FULL  = 6;
  localparam int BIT_PER   = 3;
  localparam int BIT_TEND  = 2;

  typedef struct packed {
    logic setPer;
    logic clrPer;
    logic setFull;
    logic clrFull;
    logic rxLoad;
    logic setTend;
    logic forceTend;
    logic clrTend;
  } flag_strobes_t;
endpackage

// File: rtl/sc_etu_delay.sv
module sc_etu_delay #(
  parameter int CNT_W       = 5,
  parameter int STEPS_PLAIN = 25,
  parameter int STEPS_BLOCK = 23,
  parameter int STEPS_GUARD = 22
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic halfTick,
  input  logic guardMode,
  input  logic blockMode,
  output logic expire
);
  localparam logic [CNT_W-1:0] LOAD_PLAIN = CNT_W'(STEPS_PLAIN);
  localparam logic [CNT_W-1:0] LOAD_BLOCK = CNT_W'(STEPS_BLOCK);
  localparam logic [CNT_W-1:0] LOAD_GUARD = CNT_W'(STEPS_GUARD);
  localparam logic [CNT_W-1:0] LAST_STEP  = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;
  logic             running;

  always_comb begin
    if (guardMode)      loadVal = LOAD_GUARD;
    else if (blockMode) loadVal = LOAD_BLOCK;
    else                loadVal = LOAD_PLAIN;
  end

  assign expire = running && halfTick && !start && (remain == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      remain  <= '0;
    end else if (start) begin
      running <= 1'b1;
      remain  <= loadVal;
    end else if (running && halfTick) begin
      remain <= remain - LAST_STEP;
      if (remain == LAST_STEP) running <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_status_ctrl.sv
module sc_status_ctrl
  import sc_status_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int STEPS_PLAIN = 25,
  parameter int STEPS_BLOCK = 23,
  parameter int STEPS_GUARD = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              txStart,
  input  logic              rxDone,
  input  logic              rxParityErr,
  input  logic              errSignal,
  input  logic              txEmpty,
  input  logic              guardMode,
  input  logic              blockMode,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [STAT_W-1:0] wrData,
  input  logic              dmaTxWrite,
  input  logic              parErrQ,
  input  logic              rxFullQ,
  output flag_strobes_t     strobes
);
  localparam logic [STAT_W-1:0] USED_MASK =
    STAT_W'((1 << BIT_EMPTY) | (1 << BIT_FULL) | (1 << BIT_PER));

  logic seenPer, seenFull, seenEmpty;
  logic accept, expire;
  logic unusedWr;

  assign unusedWr = ^(wrData & ~USED_MASK);

  sc_etu_delay #(
    .CNT_W(CNT_W), .STEPS_PLAIN(STEPS_PLAIN),
    .STEPS_BLOCK(STEPS_BLOCK), .STEPS_GUARD(STEPS_GUARD)
  ) uDelay (
    .clk(clk), .rstN(rstN), .start(txStart), .halfTick(halfTick),
    .guardMode(guardMode), .blockMode(blockMode), .expire(expire)
  );

  // A read arms each latch with the flag value seen; any write consumes it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenPer   <= 1'b0;
      seenFull  <= 1'b0;
      seenEmpty <= 1'b0;
    end else if (regWr) begin
      seenPer   <= 1'b0;
      seenFull  <= 1'b0;
      seenEmpty <= 1'b0;
    end else if (regRd) begin
      seenPer   <= parErrQ;
      seenFull  <= rxFullQ;
      seenEmpty <= txEmpty;
    end
  end

  assign accept = rxDone && rxEnable && !parErrQ;

  always_comb begin
    strobes.setPer    = accept && rxParityErr;
    strobes.setFull   = accept && !rxParityErr;
    strobes.rxLoad    = accept;
    strobes.clrPer    = regWr && !wrData[BIT_PER] && seenPer;
    strobes.clrFull   = regWr && !wrData[BIT_FULL] && seenFull;
    strobes.forceTend = !txEnable && !errSignal;
    strobes.setTend   = expire && !errSignal && txEmpty;
    strobes.clrTend   = dmaTxWrite || (regWr && !wrData[BIT_EMPTY] && seenEmpty);
  end
endmodule

// File: rtl/sc_status_dp.sv
module sc_status_dp
  import sc_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flag_strobes_t     strobes,
  input  logic              txEmpty,
  input  logic              syncMode,
  output logic              parErr,
  output logic              rxFull,
  output logic              txEnd,
  output logic              rxLoad,
  output logic              rxBlock,
  output logic              txBlock,
  output logic [STAT_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      parErr <= 1'b0;
      rxFull <= 1'b0;
      txEnd  <= 1'b1;
      rxLoad <= 1'b0;
    end else begin
      rxLoad <= strobes.rxLoad;
      if (strobes.setPer)       parErr <= 1'b1;
      else if (strobes.clrPer)  parErr <= 1'b0;
      if (strobes.setFull)      rxFull <= 1'b1;
      else if (strobes.clrFull) rxFull <= 1'b0;
      if (strobes.forceTend || strobes.setTend) txEnd <= 1'b1;
      else if (strobes.clrTend)                 txEnd <= 1'b0;
    end
  end

  assign rxBlock = parErr;
  assign txBlock = parErr && syncMode;

  always_comb begin
    rdData            = '0;
    rdData[BIT_EMPTY] = txEmpty;
    rdData[BIT_FULL]  = rxFull;
    rdData[BIT_PER]   = parErr;
    rdData[BIT_TEND]  = txEnd;
  end
endmodule

// File: rtl/sc_status_flags.sv
module sc_status_flags
  import sc_status_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int STEPS_PLAIN = 25,
  parameter int STEPS_BLOCK = 23,
  parameter int STEPS_GUARD = 22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              txStart,
  input  logic              rxDone,
  input  logic              rxParityErr,
  input  logic              errSignal,
  input  logic              txEmpty,
  input  logic              guardMode,
  input  logic              blockMode,
  input  logic              syncMode,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [STAT_W-1:0] wrData,
  input  logic              dmaTxWrite,
  output logic [STAT_W-1:0] rdData,
  output logic              parErr,
  output logic              rxFull,
  output logic              txEnd,
  output logic              rxLoad,
  output logic              rxBlock,
  output logic              txBlock
);
  flag_strobes_t strobes;

  sc_status_ctrl #(
    .CNT_W(CNT_W), .STEPS_PLAIN(STEPS_PLAIN),
    .STEPS_BLOCK(STEPS_BLOCK), .STEPS_GUARD(STEPS_GUARD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .txStart(txStart),
    .rxDone(rxDone), .rxParityErr(rxParityErr), .errSignal(errSignal),
    .txEmpty(txEmpty), .guardMode(guardMode), .blockMode(blockMode),
    .txEnable(txEnable), .rxEnable(rxEnable), .regRd(regRd), .regWr(regWr),
    .wrData(wrData), .dmaTxWrite(dmaTxWrite), .parErrQ(parErr),
    .rxFullQ(rxFull), .strobes(strobes)
  );

  sc_status_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .txEmpty(txEmpty),
    .syncMode(syncMode), .parErr(parErr), .rxFull(rxFull), .txEnd(txEnd),
    .rxLoad(rxLoad), .rxBlock(rxBlock), .txBlock(txBlock), .rdData(rdData)
  );
endmodule

// File: rtl/sc_status_chk.sv
module sc_status_chk (
  input logic clk,
  input logic rstN,
  input logic halfTick,
  input logic rxDone,
  input logic rxParityErr,
  input logic rxEnable,
  input logic regWr,
  input logic txEnable,
  input logic errSignal,
  input logic dmaTxWrite,
  input logic parErr,
  input logic rxFull,
  input logic txEnd,
  input logic rxLoad
);
  // R1
  parity_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rxEnable && rxParityErr && !parErr |=> parErr && rxLoad);
  // R2
  full_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && rxEnable && !rxParityErr && !parErr |=> rxFull && rxLoad);
  // R3
  stall_noload_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone && parErr |=> !rxLoad);
  // R4
  per_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    parErr && !regWr |=> parErr);
  // R5
  per_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxDone && !regWr |=> $stable(parErr));
  // R6
  tend_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable && !errSignal |=> txEnd);
  // R10
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaTxWrite && txEnable && !halfTick |=> !txEnd);
endmodule

bind sc_status_flags sc_status_chk uChk (.*);

// File: tb/tb_sc_status_flags.sv
module tb_sc_status_flags;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic halfTick = 0, txStart = 0, rxDone = 0, rxParityErr = 0;
  logic errSignal = 0, txEmpty = 0, guardMode = 0, blockMode = 0;
  logic syncMode = 0, txEnable = 0, rxEnable = 0;
  logic regRd = 0, regWr = 0, dmaTxWrite = 0;
  logic [7:0] wrData = 8'hFF;
  logic [7:0] rdData;
  logic parErr, rxFull, txEnd, rxLoad, rxBlock, txBlock;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_status_flags dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic stepc(); @(negedge clk); endtask
  task automatic tick();  halfTick = 1; stepc(); halfTick = 0; stepc(); endtask
  task automatic startTx(); txStart = 1; stepc(); txStart = 0; endtask
  task automatic rdStat(); regRd = 1; stepc(); regRd = 0; endtask
  task automatic wrStat(logic [7:0] d);
    regWr = 1; wrData = d; stepc(); regWr = 0; wrData = 8'hFF;
  endtask
  task automatic dmaWr(); dmaTxWrite = 1; stepc(); dmaTxWrite = 0; endtask
  task automatic rxChar(logic par);
    rxDone = 1; rxParityErr = par; stepc(); rxDone = 0; rxParityErr = 0;
  endtask

  function automatic int modeSteps(logic gm, logic blk);
    if (gm) return 22;
    return blk ? 23 : 25;
  endfunction

  task automatic runMode(logic gm, logic blk);
    int n;
    n = modeSteps(gm, blk);
    guardMode = gm; blockMode = blk;
    dmaWr();
    check("R10 dma clear", txEnd, 0);
    startTx();
    repeat (n - 1) tick();
    check("R7 before last tick", txEnd, 0);
    tick();
    check("R7 after last tick", txEnd, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic mPer, mFull, sPer, sFull, acc;
    void'($urandom(32'd7816));
    repeat (3) stepc();
    rstN = 1;
    stepc();
    check("R6 reset tend", txEnd, 1);
    check("R1 reset per", parErr, 0);
    check("R2 reset full", rxFull, 0);
    check("R3 reset rxBlock", rxBlock, 0);

    txEmpty = 1; txEnable = 1; stepc();
    dmaWr();
    check("R10 dma clears tend", txEnd, 0);
    txEnable = 0; stepc();
    check("R6 forced tend", txEnd, 1);
    txEnable = 1; stepc();

    runMode(0, 0);
    runMode(0, 1);
    runMode(1, 0);
    runMode(1, 1);

    // R7 restart
    guardMode = 0; blockMode = 0;
    dmaWr(); startTx();
    repeat (10) tick();
    startTx();
    repeat (24) tick();
    check("R7 restart not early", txEnd, 0);
    tick();
    check("R7 restart expiry", txEnd, 1);

    // R8 error signal at expiry
    dmaWr(); startTx();
    repeat (24) tick();
    errSignal = 1; tick(); errSignal = 0;
    check("R8 ers blocks tend", txEnd, 0);
    repeat (30) tick();
    check("R8 count abandoned", txEnd, 0);

    // R9 read-then-write clear of the empty bit
    txEnable = 0; stepc(); txEnable = 1; stepc();
    wrStat(8'h7F);
    check("R9 write without read", txEnd, 1);
    rdStat();
    check("R12 status tend bit", rdData[2], 1);
    wrStat(8'h7F);
    check("R9 read then write", txEnd, 0);

    // R11 set wins over dma clear
    startTx();
    repeat (24) tick();
    halfTick = 1; dmaTxWrite = 1; stepc(); halfTick = 0; dmaTxWrite = 0;
    check("R11 set beats clear", txEnd, 1);

    // receive path
    rxEnable = 1; syncMode = 1; stepc();
    rxChar(1);
    check("R1 per set", parErr, 1);
    check("R1 data loaded", rxLoad, 1);
    check("R1 full unchanged", rxFull, 0);
    stepc();
    check("R1 load single pulse", rxLoad, 0);
    check("R3 rxBlock", rxBlock, 1);
    check("R3 txBlock sync", txBlock, 1);
    syncMode = 0; stepc();
    check("R3 txBlock async", txBlock, 0);
    rxChar(0);
    check("R3 no load while stalled", rxLoad, 0);
    check("R3 full unchanged while stalled", rxFull, 0);
    wrStat(8'hF7);
    check("R4 write without read", parErr, 1);
    rxEnable = 0; stepc();
    check("R5 re cleared keeps per", parErr, 1);
    rxEnable = 1; stepc();
    check("R5 re set keeps per", parErr, 1);
    rdStat();
    check("R4 status per bit", rdData[3], 1);
    wrStat(8'hF7);
    check("R4 read then write", parErr, 0);
    rxChar(0);
    check("R2 full set", rxFull, 1);
    check("R2 data loaded", rxLoad, 1);
    rdStat();
    wrStat(8'hBF);
    check("R12 full cleared", rxFull, 0);

    // seeded random receive traffic against a model
    mPer = 0; mFull = 0; sPer = 0; sFull = 0;
    for (int i = 0; i < 600; i++) begin
      int op;
      logic par, en;
      logic [7:0] d;
      logic nPer, nFull;
      op = $urandom % 5;
      par = ($urandom % 3) == 0;
      en = ($urandom % 8) != 0;
      d = 8'($urandom);
      rxEnable = en;
      rxDone = (op < 2); rxParityErr = par;
      regRd = (op == 2); regWr = (op == 3); wrData = d;
      acc = rxDone && en && !mPer;
      nPer = mPer; nFull = mFull;
      if (regWr && !d[3] && sPer) nPer = 0;
      if (regWr && !d[6] && sFull) nFull = 0;
      if (acc && par) nPer = 1;
      if (acc && !par) nFull = 1;
      if (regWr) begin sPer = 0; sFull = 0; end
      else if (regRd) begin sPer = mPer; sFull = mFull; end
      mPer = nPer; mFull = nFull;
      stepc();
      rxDone = 0; regRd = 0; regWr = 0; wrData = 8'hFF;
      check("R4 random per", parErr, mPer);
      check("R12 random full", rxFull, mFull);
      check("R3 random load", rxLoad, acc);
    end

    summary();
  end
endmodule